// File: doc/BRIEF.md
# Word-Array Data Memory with Sub-Word Load Extraction

This block is the data memory of a simple 32-bit core. The storage is organised as whole words and is indexed by the word part of a byte address. A word store happens on the rising clock edge while the write enable is high. A read is purely combinational: the addressed word appears at the output in the same cycle as the address.

Byte and halfword loads read the whole word first. The low address bits then pick a lane, and the lane is sign- or zero-extended according to the load-type code. The core drives the load-type code from the funct3 field of its load instruction.

Accesses that cross a word boundary are not handled. Byte stores, halfword stores and memory-mapped I/O are not handled either.

Top module: `dmem_subword`

## Requirements
- R1: With `we_i` high at a rising clock edge, `wdata_i` is written to word `addr_i[7:2]` (default depth 64). A read of that word shows the new value right after that edge and the old value before it.
- R2: With `we_i` low, a clock edge changes no stored word, whatever `wdata_i` and `addr_i` carry.
- R3: `rdata_o` follows changes of `addr_i` and `funct3_i` in the same cycle, with no clock edge needed.
- R4: Load code 2 returns the addressed 32-bit word unchanged.
- R5: Load code 0 returns one byte, sign-extended from its bit 7. The lanes are little-endian: `addr_i[1:0]` = 0, 1, 2, 3 selects word bits 7:0, 15:8, 23:16, 31:24.
- R6: Load code 4 returns the same byte lane as code 0, zero-extended.
- R7: Load code 1 returns a halfword, sign-extended from its bit 15. `addr_i[1]` = 0 selects word bits 15:0 and 1 selects bits 31:16.
- R8: Load code 5 returns the same halfword lane as code 1, zero-extended.
- R9: Load codes 3, 6 and 7 return the full word unchanged.
- R10: Address bits above the word index are ignored. Byte address `A + 4*DEPTH`, or `A` with bit 31 set, reaches the same word as `A`.
- R11: Word stores and word loads ignore `addr_i[1:0]`, so the whole word is always written or read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock; stores take effect on its rising edge |
| addr_i | input | 32 | Byte address of the access |
| wdata_i | input | 32 | Word to be stored |
| we_i | input | 1 | High for store instructions only |
| funct3_i | input | 3 | Load type/sign code |
| rdata_o | output | 32 | Extended load result |

## Verification
A store is due at the first rising edge on which `we_i` is high. The bench drives every store on the falling edge and reads back half a period later, after exactly one rising edge. It also takes one sample before that edge to confirm that the old word is still visible. Loads have zero cycles of latency: after each change of address or code, the bench waits 1 ns without any clock edge and then samples `rdata_o`. The hold check for R2 lets three rising edges pass with `we_i` low and then reads at the same falling-edge offset.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned HALF_W = 16;

  // load-type codes match the funct3 field of load instructions
  typedef enum logic [2:0] {
    LD_BYTE  = 3'd0,
    LD_HALF  = 3'd1,
    LD_WORD  = 3'd2,
    LD_BYTEU = 3'd4,
    LD_HALFU = 3'd5
  } ld_kind_e;
endpackage

// File: rtl/dmem_word_array.sv
module dmem_word_array #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[idx_i] <= wdata_i;
  end

  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/dmem_lane_select.sv
module dmem_lane_select #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned N_LANE = DATA_W / LANE_W,
  localparam int unsigned SEL_W  = $clog2(N_LANE)
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic [LANE_W-1:0] lane_o
);
  logic [LANE_W-1:0] lanes [N_LANE];

  for (genvar g = 0; g < N_LANE; g++) begin : g_lane
    assign lanes[g] = word_i[g*LANE_W +: LANE_W];
  end

  assign lane_o = lanes[sel_i];
endmodule

// File: rtl/dmem_load_extend.sv
module dmem_load_extend
  import dmem_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [2:0]        funct3_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [HALF_W-1:0] half_i,
  output logic [DATA_W-1:0] data_o
);
  always_comb begin
    case (funct3_i)
      LD_BYTE:  data_o = {{(DATA_W-BYTE_W){byte_i[BYTE_W-1]}}, byte_i};
      LD_BYTEU: data_o = {{(DATA_W-BYTE_W){1'b0}}, byte_i};
      LD_HALF:  data_o = {{(DATA_W-HALF_W){half_i[HALF_W-1]}}, half_i};
      LD_HALFU: data_o = {{(DATA_W-HALF_W){1'b0}}, half_i};
      default:  data_o = word_i; // word load and unused codes
    endcase
  end
endmodule

// File: rtl/dmem_subword.sv
module dmem_subword
  import dmem_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 64
) (
  input  logic              clk_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic [2:0]        funct3_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned OFS_W = $clog2(DATA_W / BYTE_W);
  localparam int unsigned IDX_W = $clog2(DEPTH);

  logic [IDX_W-1:0]  word_idx;
  logic [DATA_W-1:0] word_rd;
  logic [BYTE_W-1:0] byte_sel;
  logic [HALF_W-1:0] half_sel;
  logic              unused_addr;

  assign word_idx    = addr_i[OFS_W +: IDX_W];
  assign unused_addr = ^{addr_i[ADDR_W-1:OFS_W+IDX_W], addr_i[OFS_W-1:0]};

  dmem_word_array #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_array (
    .clk_i  (clk_i),
    .we_i   (we_i),
    .idx_i  (word_idx),
    .wdata_i(wdata_i),
    .rdata_o(word_rd)
  );

  dmem_lane_select #(.DATA_W(DATA_W), .LANE_W(BYTE_W)) i_byte_sel (
    .word_i(word_rd),
    .sel_i (addr_i[OFS_W-1:0]),
    .lane_o(byte_sel)
  );

  dmem_lane_select #(.DATA_W(DATA_W), .LANE_W(HALF_W)) i_half_sel (
    .word_i(word_rd),
    .sel_i (addr_i[OFS_W-1:1]),
    .lane_o(half_sel)
  );

  dmem_load_extend #(.DATA_W(DATA_W)) i_extend (
    .funct3_i(funct3_i),
    .word_i  (word_rd),
    .byte_i  (byte_sel),
    .half_i  (half_sel),
    .data_o  (rdata_o)
  );
endmodule

// File: rtl/dmem_subword_chk.sv
module dmem_subword_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 64
) (
  input logic              clk_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              we_i,
  input logic [2:0]        funct3_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [DATA_W-1:0] word_rd
);
  localparam int unsigned IDX_W = $clog2(DEPTH);

  logic armed = 1'b0;
  logic [7:0]  exp_byte;
  logic [15:0] exp_half;

  always_ff @(posedge clk_i) armed <= 1'b1;

  assign exp_byte = word_rd[8*addr_i[1:0] +: 8];
  assign exp_half = addr_i[1] ? word_rd[31:16] : word_rd[15:0];

  // R1 store visible on the next cycle at the same word
  a_r1_store_lands: assert property (@(posedge clk_i) disable iff (!armed)
    we_i |=> (addr_i[2 +: IDX_W] != $past(addr_i[2 +: IDX_W]) || funct3_i != 3'd2
              || rdata_o == $past(wdata_i)));

  // R2 no store keeps a stable read stable
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!armed)
    !we_i |=> (!$stable(addr_i) || !$stable(funct3_i) || $stable(rdata_o)));

  // R4 word load passes the array word
  a_r4_word: assert property (@(posedge clk_i) disable iff (!armed)
    funct3_i == 3'd2 |-> rdata_o == word_rd);

  // R5 signed byte load
  a_r5_byte_sext: assert property (@(posedge clk_i) disable iff (!armed)
    funct3_i == 3'd0 |-> rdata_o == {{24{exp_byte[7]}}, exp_byte});

  // R6 unsigned byte load
  a_r6_byte_zext: assert property (@(posedge clk_i) disable iff (!armed)
    funct3_i == 3'd4 |-> rdata_o == {24'd0, exp_byte});

  // R7 signed halfword load
  a_r7_half_sext: assert property (@(posedge clk_i) disable iff (!armed)
    funct3_i == 3'd1 |-> rdata_o == {{16{exp_half[15]}}, exp_half});

  // R8 unsigned halfword load
  a_r8_half_zext: assert property (@(posedge clk_i) disable iff (!armed)
    funct3_i == 3'd5 |-> rdata_o == {16'd0, exp_half});

  // R9 unused codes return the word
  a_r9_other_codes: assert property (@(posedge clk_i) disable iff (!armed)
    (funct3_i == 3'd3 || funct3_i[2:1] == 2'b11) |-> rdata_o == word_rd);
endmodule

bind dmem_subword dmem_subword_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)
) i_chk (
  .clk_i   (clk_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .we_i    (we_i),
  .funct3_i(funct3_i),
  .rdata_o (rdata_o),
  .word_rd (word_rd)
);

// File: tb/test_dmem_subword.sv
module test_dmem_subword;
  localparam int unsigned DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [2:0]  f3 = 3'd2;
  logic [31:0] rdata;
  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  dmem_subword #(.DEPTH(DEPTH)) i_dmem_subword (
    .clk_i   (clk),
    .addr_i  (addr),
    .wdata_i (wdata),
    .we_i    (we),
    .funct3_i(f3),
    .rdata_o (rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic store(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1; f3 = 3'd2;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic load(input logic [31:0] a, input logic [2:0] f, output logic [31:0] r);
    addr = a; f3 = f;
    #1;
    r = rdata;
  endtask

  task automatic t_init;
    logic [31:0] r;
    store(32'h10, 32'h8081_7F80);
    store(32'h20, 32'h0000_0000);
    store(32'h30, 32'h0000_0000);
    load(32'h10, 3'd2, r); check("R1 init word 0x10", r, 32'h8081_7F80);
    load(32'h20, 3'd2, r); check("R4 init word 0x20", r, 32'h0);
  endtask

  task automatic t_write_timing;
    logic [31:0] r;
    @(negedge clk);
    addr = 32'h20; wdata = 32'hA5A5_0F0F; we = 1'b1; f3 = 3'd2;
    #1; r = rdata;
    check("R1 old value before edge", r, 32'h0);
    @(negedge clk);
    we = 1'b0;
    #1; r = rdata;
    check("R1 new value after edge", r, 32'hA5A5_0F0F);
  endtask

  task automatic t_no_write;
    logic [31:0] r;
    @(negedge clk);
    addr = 32'h10; wdata = 32'hFFFF_FFFF; we = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    load(32'h10, 3'd2, r); check("R2 hold 0x10", r, 32'h8081_7F80);
    load(32'h20, 3'd2, r); check("R2 hold 0x20", r, 32'hA5A5_0F0F);
  endtask

  task automatic t_comb_read;
    logic [31:0] r;
    @(negedge clk);
    load(32'h10, 3'd2, r); check("R3 read 0x10", r, 32'h8081_7F80);
    load(32'h20, 3'd2, r); check("R3 addr change, no edge", r, 32'hA5A5_0F0F);
    load(32'h20, 3'd4, r); check("R3 code change, no edge", r, 32'h0F);
  endtask

  task automatic t_bytes;
    logic [31:0] r;
    load(32'h10, 3'd0, r); check("R5 lb lane0", r, 32'hFFFF_FF80);
    load(32'h11, 3'd0, r); check("R5 lb lane1", r, 32'h0000_007F);
    load(32'h12, 3'd0, r); check("R5 lb lane2", r, 32'hFFFF_FF81);
    load(32'h13, 3'd0, r); check("R5 lb lane3", r, 32'hFFFF_FF80);
    load(32'h10, 3'd4, r); check("R6 lbu lane0", r, 32'h0000_0080);
    load(32'h12, 3'd4, r); check("R6 lbu lane2", r, 32'h0000_0081);
    load(32'h11, 3'd4, r); check("R6 lbu lane1", r, 32'h0000_007F);
  endtask

  task automatic t_halves;
    logic [31:0] r;
    load(32'h10, 3'd1, r); check("R7 lh low", r, 32'h0000_7F80);
    load(32'h12, 3'd1, r); check("R7 lh high", r, 32'hFFFF_8081);
    load(32'h10, 3'd5, r); check("R8 lhu low", r, 32'h0000_7F80);
    load(32'h12, 3'd5, r); check("R8 lhu high", r, 32'h0000_8081);
  endtask

  task automatic t_other_codes;
    logic [31:0] r;
    for (int c = 3; c < 8; c++) begin
      if (c == 4 || c == 5) continue;
      load(32'h11, c[2:0], r); check("R9 unused code", r, 32'h8081_7F80);
    end
  endtask

  task automatic t_alias;
    logic [31:0] r;
    store(32'h20 + 4*DEPTH, 32'hDEAD_BEEF);
    load(32'h20, 3'd2, r);        check("R10 alias by depth", r, 32'hDEAD_BEEF);
    load(32'h8000_0020, 3'd2, r); check("R10 alias bit 31", r, 32'hDEAD_BEEF);
    load(32'h10, 3'd2, r);        check("R10 other word intact", r, 32'h8081_7F80);
  endtask

  task automatic t_low_bits;
    logic [31:0] r;
    store(32'h33, 32'h1234_5678);
    load(32'h30, 3'd2, r); check("R11 store ignores low bits", r, 32'h1234_5678);
    load(32'h30, 3'd4, r); check("R11 full word stored, lane0", r, 32'h0000_0078);
    load(32'h13, 3'd2, r); check("R11 load ignores low bits", r, 32'h8081_7F80);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_init();
    t_write_timing();
    t_no_write();
    t_comb_read();
    t_bytes();
    t_halves();
    t_other_codes();
    t_alias();
    t_low_bits();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule